// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer with Bus Release

This block runs single-master read and write cycles on a processor bus whose address and data share one set of lines. A request (direction, memory or IO space, address and write data) is taken from a simple valid input while the sequencer is idle. The cycle then steps through an address phase with the address strobe high, a strobe phase with the active-low read or write strobe and data enable asserted, a wait phase used only by reads and stretched while the slave holds `ready` low, and a closing phase in which read data is sampled from the bus. Writes leave out the wait phase.

The bus pins {`m_io`, `rd_n`, `wr_n`} are decoded into four one-hot command strobes for memory read, memory write, IO read and IO write. A hold request from a DMA controller is honoured only between cycles. The sequencer first floats the bus and then acknowledges one clock later. It keeps the acknowledge high until the request is withdrawn, and then goes back to idle.

Top module: `mmbus_ctrl`

## Requirements
- R1: While reset is active and in the first idle cycle after it, `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `hlda`=0, `ctrl_oe`=1 and all four command strobes are 0.
- R2: `ale` is high for exactly one clock per bus cycle, the first clock after acceptance. During that clock `ad_out` carries the request address and `ad_oe`=1.
- R3: `den_n` is never low while `ale` is high. It goes low in the clock after the address phase and stays low for as many clocks as the read or write strobe.
- R4: `dt_r` is 1 for a write cycle and 0 for a read cycle, and it does not change while `den_n` is low.
- R5: With `ready` high, a read strobe lasts 3 clocks (strobe, wait, closing) and a write strobe lasts 2 clocks (strobe, closing). During a write strobe `ad_out[15:0]` carries the write data with `ad_oe`=1.
- R6: Each clock of the wait phase in which `ready` is sampled low adds one clock to the read strobe.
- R7: Read data is sampled from `ad_in` on the last clock of the read strobe. `rd_data` shows it, and `cyc_done` pulses for one clock, in the clock after the cycle ends. Writes also pulse `cyc_done`.
- R8: The command decoder uses index {m_io, rd_n, wr_n}. Index 1 gives `cmd_io_rd`, 2 gives `cmd_io_wr`, 5 gives `cmd_mem_rd` and 6 gives `cmd_mem_wr`. Every other index, or `ctrl_oe`=0, gives no command. At most one command is active.
- R9: `rd_n` and `wr_n` are never low in the same clock.
- R10: `hold` is sampled only in idle. A cycle already under way runs to completion, with `hlda` low, before the bus is released.
- R11: In the clock after `hold` is taken, `ctrl_oe` and `ad_oe` go low with `hlda` still 0. `hlda` rises one clock later and, while it is high, `ctrl_oe` and `ad_oe` stay 0.
- R12: A request is accepted only in idle. A `req_valid` pulse during a bus cycle or during a hold produces no bus cycle.
- R13: One clock after `hold` is withdrawn, `hlda` is 0 and `ctrl_oe` is 1, and the next request runs a normal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (taken only in idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = IO space |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| cyc_done | output | 1 | One-clock pulse after a cycle ends |
| rd_data | output | 16 | Last sampled read data |
| ready | input | 1 | Slave ready, sampled in the read wait phase |
| hold | input | 1 | Bus release request from DMA |
| hlda | output | 1 | Bus release acknowledge |
| ale | output | 1 | Address strobe |
| den_n | output | 1 | Data enable, active low |
| dt_r | output | 1 | Direction: 1 transmit, 0 receive |
| m_io | output | 1 | 1 memory, 0 IO |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctrl_oe | output | 1 | Output enable for the control pins |
| ad_out | output | 20 | Multiplexed address/data drive value |
| ad_oe | output | 1 | Output enable for the multiplexed lines |
| ad_in | input | 16 | Data returned on the multiplexed lines |
| cmd_mem_rd | output | 1 | Decoded memory read |
| cmd_mem_wr | output | 1 | Decoded memory write |
| cmd_io_rd | output | 1 | Decoded IO read |
| cmd_io_wr | output | 1 | Decoded IO write |

## Verification
The hardest case to reach is a hold request that arrives while a stretched read is still running. The bench raises `hold` in the address clock of a read that has two wait clocks. It then watches, clock by clock, that `hlda` stays low and the strobe runs its full length, that the cycle completes, and that the bus floats before `hlda` rises. A `req_valid` pulse is also sent during the strobe phase of one cycle and during a hold. The bench confirms that neither pulse leads to a command strobe or a `cyc_done`. The bench memory model derives `ready` from the age of the read strobe, so the wait length is set exactly for each transaction.

// File: rtl/mmbus_pkg.sv
package mmbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_STROBE,
        PH_WAIT,
        PH_DONE,
        PH_RELEASE,
        PH_HELD
    } bus_phase_e;

    typedef struct packed {
        logic ale;
        logic den_n;
        logic dt_r;
        logic m_io;
        logic rd_n;
        logic wr_n;
        logic ctrl_oe;
    } bus_pins_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } bus_cmd_t;

    localparam logic [2:0] CODE_IO_RD  = 3'd1;
    localparam logic [2:0] CODE_IO_WR  = 3'd2;
    localparam logic [2:0] CODE_MEM_RD = 3'd5;
    localparam logic [2:0] CODE_MEM_WR = 3'd6;

    function automatic bus_cmd_t decode_cmd(input logic [2:0] idx);
        bus_cmd_t c;
        c = '0;
        case (idx)
            CODE_IO_RD:  c.io_rd  = 1'b1;
            CODE_IO_WR:  c.io_wr  = 1'b1;
            CODE_MEM_RD: c.mem_rd = 1'b1;
            CODE_MEM_WR: c.mem_wr = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

    function automatic logic in_strobe(input bus_phase_e ph);
        return (ph == PH_STROBE) || (ph == PH_WAIT) || (ph == PH_DONE);
    endfunction

endpackage

// File: rtl/mmbus_fsm.sv
module mmbus_fsm
    import mmbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       hold,
    input  logic       ready,
    output bus_phase_e phase,
    output logic       accept,
    output logic       cur_write,
    output logic       capture,
    output logic       done,
    output logic       hlda
);

    bus_phase_e nxt;

    always_comb begin
        nxt    = phase;
        accept = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (hold) begin
                    nxt = PH_RELEASE;
                end else if (req_valid) begin
                    nxt    = PH_ADDR;
                    accept = 1'b1;
                end
            end
            PH_ADDR:    nxt = PH_STROBE;
            PH_STROBE:  nxt = cur_write ? PH_DONE : PH_WAIT;
            PH_WAIT:    nxt = ready ? PH_DONE : PH_WAIT;
            PH_DONE:    nxt = PH_IDLE;
            PH_RELEASE: nxt = hold ? PH_HELD : PH_IDLE;
            PH_HELD:    nxt = hold ? PH_HELD : PH_IDLE;
            default:    nxt = PH_IDLE;
        endcase
    end

    assign capture = (phase == PH_DONE) && !cur_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cur_write <= 1'b0;
            done      <= 1'b0;
            hlda      <= 1'b0;
        end else begin
            phase <= nxt;
            done  <= (phase == PH_DONE);
            hlda  <= (nxt == PH_HELD);
            if (accept) begin
                cur_write <= req_write;
            end
        end
    end

    // R5: writes never enter the wait phase
    p_write_nowait_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT) |-> !cur_write);

    // R10: the bus is released only from an idle boundary
    p_hold_boundary_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RELEASE) |-> $past(phase == PH_IDLE));

    // R12: an accepted request always opens with the address phase
    p_accept_idle_r12: assert property (@(posedge clk) disable iff (rst)
        accept |=> (phase == PH_ADDR));

endmodule

// File: rtl/mmbus_dpath.sv
module mmbus_dpath
    import mmbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_phase_e        phase,
    input  logic              accept,
    input  logic              capture,
    input  logic              cur_write,
    input  logic              req_mem,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output bus_pins_t         pins,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              mem_q;
    logic [ADDR_W-1:0] wdata_wide;
    logic              strobing;
    logic              busy;
    logic              released;

    generate
        if (PAD_W > 0) begin : g_pad
            assign wdata_wide = {{PAD_W{1'b0}}, wdata_q};
        end else begin : g_nopad
            assign wdata_wide = wdata_q[ADDR_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mem_q   <= 1'b0;
            rd_data <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mem_q   <= req_mem;
            end
            if (capture) begin
                rd_data <= ad_in;
            end
        end
    end

    assign strobing = in_strobe(phase);
    assign busy     = strobing || (phase == PH_ADDR);
    assign released = (phase == PH_RELEASE) || (phase == PH_HELD);

    always_comb begin
        pins.ale     = (phase == PH_ADDR);
        pins.den_n   = !strobing;
        pins.dt_r    = busy && cur_write;
        pins.m_io    = mem_q;
        pins.rd_n    = !(strobing && !cur_write);
        pins.wr_n    = !(strobing && cur_write);
        pins.ctrl_oe = !released;
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        if (phase == PH_ADDR) begin
            ad_out = addr_q;
            ad_oe  = 1'b1;
        end else if (strobing && cur_write) begin
            ad_out = wdata_wide;
            ad_oe  = 1'b1;
        end
    end

endmodule

// File: rtl/mmbus_cmd_dec.sv
module mmbus_cmd_dec
    import mmbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     m_io,
    input  logic     rd_n,
    input  logic     wr_n,
    output bus_cmd_t cmd
);

    logic [2:0] idx;

    assign idx = {m_io, rd_n, wr_n};
    assign cmd = en ? decode_cmd(idx) : '0;

    // R8: at most one command strobe at a time
    p_cmd_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd));

endmodule

// File: rtl/mmbus_ctrl.sv
module mmbus_ctrl
    import mmbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cyc_done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda,
    output logic              ale,
    output logic              den_n,
    output logic              dt_r,
    output logic              m_io,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ctrl_oe,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              cmd_mem_rd,
    output logic              cmd_mem_wr,
    output logic              cmd_io_rd,
    output logic              cmd_io_wr
);

    bus_phase_e phase;
    logic       accept;
    logic       cur_write;
    logic       capture;
    bus_pins_t  pins;
    bus_cmd_t   cmd;

    mmbus_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .hold      (hold),
        .ready     (ready),
        .phase     (phase),
        .accept    (accept),
        .cur_write (cur_write),
        .capture   (capture),
        .done      (cyc_done),
        .hlda      (hlda)
    );

    mmbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .accept    (accept),
        .capture   (capture),
        .cur_write (cur_write),
        .req_mem   (req_mem),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .pins      (pins),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .rd_data   (rd_data)
    );

    assign ale     = pins.ale;
    assign den_n   = pins.den_n;
    assign dt_r    = pins.dt_r;
    assign m_io    = pins.m_io;
    assign rd_n    = pins.rd_n;
    assign wr_n    = pins.wr_n;
    assign ctrl_oe = pins.ctrl_oe;

    mmbus_cmd_dec u_dec (
        .clk  (clk),
        .rst  (rst),
        .en   (pins.ctrl_oe),
        .m_io (pins.m_io),
        .rd_n (pins.rd_n),
        .wr_n (pins.wr_n),
        .cmd  (cmd)
    );

    assign cmd_mem_rd = cmd.mem_rd;
    assign cmd_mem_wr = cmd.mem_wr;
    assign cmd_io_rd  = cmd.io_rd;
    assign cmd_io_wr  = cmd.io_wr;

    // R2: address strobe lasts a single clock
    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R3: data enable stays off during the address phase
    p_den_off_in_addr_r3: assert property (@(posedge clk) disable iff (rst)
        ale |-> den_n);

    // R3: data enable falls right after the address phase
    p_den_after_ale_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(den_n) |-> $past(ale));

    // R4: direction is steady while data is enabled
    p_dt_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!den_n && $past(!den_n)) |-> $stable(dt_r));

    // R9: read and write strobes are exclusive
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R11: the bus floats whenever hold is acknowledged
    p_float_hold_r11: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ctrl_oe && !ad_oe));

    // R11: acknowledge only follows a clock of floated bus
    p_hlda_lag_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> $past(!ctrl_oe));

endmodule

// File: tb/mmbus_ctrl_tb_top.sv
module mmbus_ctrl_tb_top;

    localparam int AW = 20;
    localparam int DW = 16;

    typedef struct {
        logic [3:0]    kind;   // {mem_rd, mem_wr, io_rd, io_wr}
        int            len;
        logic [AW-1:0] addr;
        logic          dt;
        logic          is_read;
        logic [DW-1:0] data;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_mem = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          cyc_done;
    logic [DW-1:0] rd_data;
    logic          ready = 1'b1;
    logic          hold = 1'b0;
    logic          hlda, ale, den_n, dt_r, m_io, rd_n, wr_n, ctrl_oe, ad_oe;
    logic [AW-1:0] ad_out;
    logic [DW-1:0] ad_in;
    logic          cmd_mem_rd, cmd_mem_wr, cmd_io_rd, cmd_io_wr;

    int checks = 0;
    int failures = 0;
    int stray_done = 0;
    int waits_cfg = 0;
    int age = 0;
    logic [AW-1:0] lat_addr = '0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    mmbus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_addr(req_addr), .req_wdata(req_wdata),
        .cyc_done(cyc_done), .rd_data(rd_data), .ready(ready), .hold(hold),
        .hlda(hlda), .ale(ale), .den_n(den_n), .dt_r(dt_r), .m_io(m_io),
        .rd_n(rd_n), .wr_n(wr_n), .ctrl_oe(ctrl_oe), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .cmd_mem_rd(cmd_mem_rd),
        .cmd_mem_wr(cmd_mem_wr), .cmd_io_rd(cmd_io_rd), .cmd_io_wr(cmd_io_wr)
    );

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A3};
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bench memory: returns data while reading, stretches by waits_cfg
    assign ad_in = !rd_n ? mem_val(lat_addr) : '0;

    always @(negedge clk) begin
        if (ale) lat_addr <= ad_out;
        if (!rd_n) begin
            age   = age + 1;
            ready <= (age >= 2 + waits_cfg);
        end else begin
            age   = 0;
            ready <= 1'b1;
        end
    end

    // monitor: gathers what happens on the pins and compares against queue
    int            m_ale = 0, m_strb = 0, m_den = 0;
    logic [3:0]    m_kind = '0;
    logic [AW-1:0] m_addr = '0;
    logic          m_dt = 1'b0;
    logic [DW-1:0] m_wd = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ale) begin
                m_ale++;
                m_addr = ad_out;
                m_dt   = dt_r;
                if (!den_n) chk(1'b0, "R3 den_n low with ale", den_n, 1);
            end
            if (!rd_n && !wr_n) chk(1'b0, "R9 both strobes low", 0, 1);
            if (!den_n) m_den++;
            if (cmd_mem_rd | cmd_mem_wr | cmd_io_rd | cmd_io_wr) begin
                m_strb++;
                m_kind = m_kind | {cmd_mem_rd, cmd_mem_wr, cmd_io_rd, cmd_io_wr};
                if (!wr_n && ad_oe) m_wd = ad_out[DW-1:0];
            end
            if (cyc_done) begin
                if (exp_q.size() == 0) begin
                    stray_done++;
                    chk(1'b0, "R12 cycle with no request", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(m_kind == e.kind, "R8 decoded command", m_kind, e.kind);
                    chk(m_strb == e.len, "R5/R6 strobe length", m_strb, e.len);
                    chk(m_ale == 1, "R2 ale clocks", m_ale, 1);
                    chk(m_addr == e.addr, "R2 address phase value", m_addr, e.addr);
                    chk(m_den == e.len, "R3 den_n low length", m_den, e.len);
                    chk(m_dt == e.dt, "R4 direction", m_dt, e.dt);
                    if (e.is_read)
                        chk(rd_data == e.data, "R7 read data", rd_data, e.data);
                    else
                        chk(m_wd == e.data, "R5 write data on bus", m_wd, e.data);
                end
                m_ale = 0; m_strb = 0; m_den = 0; m_kind = '0; m_wd = '0;
            end
        end
    end

    function automatic exp_t mk_exp(input logic w, input logic m, input logic [AW-1:0] a,
                                    input logic [DW-1:0] d, input int waits);
        exp_t e;
        e.kind    = {m & ~w, m & w, ~m & ~w, ~m & w};
        e.len     = w ? 2 : 3 + waits;
        e.addr    = a;
        e.dt      = w;
        e.is_read = !w;
        e.data    = w ? d : mem_val(a);
        return e;
    endfunction

    task automatic put_req(input logic w, input logic m, input logic [AW-1:0] a,
                           input logic [DW-1:0] d);
        req_write = w; req_mem = m; req_addr = a; req_wdata = d; req_valid = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cyc_done) return;
        end
        chk(1'b0, "R7 cycle never completed", 0, 1);
    endtask

    // driver: push expectation, pulse request, wait for completion
    task automatic run_txn(input logic w, input logic m, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input int waits);
        @(negedge clk);
        waits_cfg = waits;
        exp_q.push_back(mk_exp(w, m, a, d, waits));
        put_req(w, m, a, d);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(ale == 0 && rd_n && wr_n && den_n, "R1 strobes in reset", {ale, rd_n, wr_n, den_n}, 4'b0111);
        chk(hlda == 0 && ctrl_oe, "R1 hold pins in reset", {hlda, ctrl_oe}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        chk({cmd_mem_rd, cmd_mem_wr, cmd_io_rd, cmd_io_wr} == 4'b0, "R1 no command after reset",
            {cmd_mem_rd, cmd_mem_wr, cmd_io_rd, cmd_io_wr}, 0);
        chk(ale == 0 && den_n && !hlda, "R1 idle after reset", {ale, den_n, hlda}, 3'b010);

        // main function: several patterns (R2..R8)
        run_txn(1'b0, 1'b1, 20'hA1234, '0, 0);       // memory read
        run_txn(1'b0, 1'b0, 20'h00FE0, '0, 1);       // IO read, one wait (R6)
        run_txn(1'b1, 1'b1, 20'hFFFFF, 16'hBEEF, 0); // memory write
        run_txn(1'b1, 1'b0, 20'h00042, 16'h1357, 3); // IO write, ready ignored
        run_txn(1'b0, 1'b1, 20'h5_0F0F, '0, 3);      // memory read, three waits (R6)
        run_txn(1'b0, 1'b1, 20'h0_0000, '0, 0);

        // R12: request during a running cycle is dropped
        @(negedge clk);
        waits_cfg = 2;
        exp_q.push_back(mk_exp(1'b0, 1'b1, 20'h3C3C3, '0, 2));
        put_req(1'b0, 1'b1, 20'h3C3C3, '0);
        @(negedge clk);
        req_valid = 1'b0;                 // address phase
        @(negedge clk);
        put_req(1'b1, 1'b0, 20'h00777, 16'hDEAD); // strobe phase
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (6) @(negedge clk);
        chk(stray_done == 0, "R12 busy request ignored", stray_done, 0);
        chk(exp_q.size() == 0, "R12 queue drained", exp_q.size(), 0);

        // R11/R13/R12: hold taken in idle
        hold = 1'b1;
        @(negedge clk);
        chk(!hlda && !ctrl_oe && !ad_oe, "R11 bus floats before ack", {hlda, ctrl_oe, ad_oe}, 0);
        @(negedge clk);
        chk(hlda && !ctrl_oe && !ad_oe, "R11 ack one clock later", {hlda, ctrl_oe, ad_oe}, 3'b100);
        put_req(1'b1, 1'b1, 20'h12345, 16'h0F0F);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(hlda && {cmd_mem_rd, cmd_mem_wr, cmd_io_rd, cmd_io_wr} == 4'b0,
                "R11 held with no command", {hlda, cmd_mem_rd, cmd_mem_wr, cmd_io_rd, cmd_io_wr}, 5'b10000);
        end
        hold = 1'b0;
        @(negedge clk);
        chk(!hlda && ctrl_oe, "R13 bus returned", {hlda, ctrl_oe}, 2'b01);
        repeat (5) @(negedge clk);
        chk(stray_done == 0 && exp_q.size() == 0, "R12 request during hold ignored", stray_done, 0);
        run_txn(1'b1, 1'b1, 20'h2_2222, 16'hA5A5, 0); // R13 normal cycle after hold

        // R10: hold raised during a stretched read
        @(negedge clk);
        waits_cfg = 2;
        exp_q.push_back(mk_exp(1'b0, 1'b0, 20'h0_0ABC, '0, 2));
        put_req(1'b0, 1'b0, 20'h0_0ABC, '0);
        @(negedge clk);
        req_valid = 1'b0;
        hold = 1'b1;
        begin : mid_hold
            int n;
            n = 0;
            while (!cyc_done && n < 40) begin
                chk(!hlda && ctrl_oe, "R10 cycle keeps the bus", {hlda, ctrl_oe}, 2'b01);
                @(negedge clk);
                n++;
            end
        end
        chk(cyc_done && !hlda && ctrl_oe, "R10 cycle completed before release",
            {cyc_done, hlda, ctrl_oe}, 3'b101);
        @(negedge clk);
        chk(!hlda && !ctrl_oe, "R11 release after cycle", {hlda, ctrl_oe}, 0);
        @(negedge clk);
        chk(hlda, "R11 ack after release", hlda, 1);
        hold = 1'b0;
        @(negedge clk);
        chk(!hlda && ctrl_oe, "R13 hlda drops", {hlda, ctrl_oe}, 2'b01);
        run_txn(1'b0, 1'b0, 20'h0_0011, '0, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && stray_done == 0, "R7 every cycle completed", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule